// File: doc/BRIEF.md
# Dual-Channel Energy Sum and Map Peak Finder

This block sits at the entry of an energy-map datapath. Two input channels each deliver a 32-bit word that packs two consecutive 16-bit energy samples. A word arrives at most once every two clock cycles. Each channel is unpacked into a 16-bit stream at the full clock rate, earlier sample first. The two streams are added sample by sample with a saturating adder, and the summed stream is output.

The summed samples form square maps of 20 rows by 20 columns, scanned row by row. A frame-start flag on the word that carries a map's first sample opens the map. Over the 400 samples of the map the block keeps the largest summed value and the row and column where it first appeared. One cycle after the map's last sample it presents the maximum and its packed index with a single-cycle valid pulse.

Top module: `energy_front_end`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `sum_valid`, `sum_data`, `max_valid`, `max_value` and `max_index` are all zero.
- R2: Bits 15:0 of an input word form the earlier sample and bits 31:16 the later one. For a strobe sampled at clock edge P, the low-half sum is on `sum_data` with `sum_valid` high after edge P+1, and the high-half sum after edge P+2.
- R3: Each summed sample is the unsigned sum of the two channels' samples at the same stream position, clamped to 16'hFFFF when the true sum exceeds 16 bits.
- R4: Strobes may be spaced two or more cycles apart. The summed stream keeps input order and has exactly two samples per strobe.
- R5: A strobe with `frame_start` high opens a map whose first sample is that word's low half. The map closes after 400 summed samples.
- R6: `max_value` is the largest summed sample of the closed map.
- R7: `max_index` is {row[4:0], col[4:0]}, with row in bits 9:5 and col in bits 4:0. Position p in the map (0..399) has row p/20 and col p%20. When the maximum occurs more than once, the earliest position is reported.
- R8: `max_valid` is high for exactly one cycle, after the clock edge that follows the cycle in which the map's last sample is valid on `sum_data`. `max_value` and `max_index` hold their values until the next pulse.
- R9: Samples that arrive after a map has closed and before the next `frame_start` still appear on the summed stream. They cause no `max_valid` pulse and do not affect the result of the next map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| word_strobe | input | 1 | Both channel words are valid this cycle |
| frame_start | input | 1 | This word carries the first sample of a map |
| chan_a_word | input | 32 | Channel A packed sample pair |
| chan_b_word | input | 32 | Channel B packed sample pair |
| sum_valid | output | 1 | `sum_data` holds a new summed sample |
| sum_data | output | 16 | Saturated sum of the two channels |
| max_valid | output | 1 | One-cycle pulse: map result is ready |
| max_value | output | 16 | Largest summed sample of the last map |
| max_index | output | 10 | {row, col} of that sample |

## Verification
The bench builds the block with its default 20 by 20 map and 16-bit samples. This means every check covers a full-size map, including the row wrap at column 19 and a peak at the final position, row 19 column 19. Random maps are drawn both from the full 16-bit range, where many sums clamp, and from a reduced range, where none do. Directed maps add all-equal and all-clamped frames, in which the first position wins the tie, and a planted duplicate peak. The strobe spacing alternates between two and three cycles, so both the back-to-back and the gapped unpacking paths are covered.

// File: rtl/efe_pkg.sv
package efe_pkg;

    parameter int unsigned SAMPLE_W = 16;
    parameter int unsigned WORD_W   = 2 * SAMPLE_W;

    typedef struct packed {
        logic                valid;
        logic                first;
        logic [SAMPLE_W-1:0] data;
    } sample_t;

    function automatic logic [SAMPLE_W-1:0] sat_add(
        input logic [SAMPLE_W-1:0] x,
        input logic [SAMPLE_W-1:0] y
    );
        logic [SAMPLE_W:0] wide;
        wide = {1'b0, x} + {1'b0, y};
        return wide[SAMPLE_W] ? {SAMPLE_W{1'b1}} : wide[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/chan_serializer.sv
module chan_serializer
    import efe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              first_in,
    input  logic [WORD_W-1:0] word,
    output sample_t           out_s
);

    logic [SAMPLE_W-1:0] hold_q;
    logic                pend_q;

    // Low half leaves first, the high half is parked for one cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_s  <= '0;
            hold_q <= '0;
            pend_q <= 1'b0;
        end else if (strobe) begin
            out_s.valid <= 1'b1;
            out_s.first <= first_in;
            out_s.data  <= word[SAMPLE_W-1:0];
            hold_q      <= word[WORD_W-1:SAMPLE_W];
            pend_q      <= 1'b1;
        end else if (pend_q) begin
            out_s.valid <= 1'b1;
            out_s.first <= 1'b0;
            out_s.data  <= hold_q;
            pend_q      <= 1'b0;
        end else begin
            out_s.valid <= 1'b0;
            out_s.first <= 1'b0;
        end
    end

endmodule

// File: rtl/sat_sum_stage.sv
module sat_sum_stage
    import efe_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sample_t a_s,
    input  sample_t b_s,
    output sample_t sum_s
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_s <= '0;
        end else begin
            sum_s.valid <= a_s.valid;
            sum_s.first <= a_s.valid & a_s.first;
            if (a_s.valid) begin
                sum_s.data <= sat_add(a_s.data, b_s.data);
            end
        end
    end

endmodule

// File: rtl/map_max_tracker.sv
module map_max_tracker
    import efe_pkg::*;
#(
    parameter int unsigned ROWS = 20,
    parameter int unsigned COLS = 20,
    localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned COL_W = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int unsigned IDX_W = ROW_W + COL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  sample_t             in_s,
    output logic                res_valid,
    output logic [SAMPLE_W-1:0] res_max,
    output logic [IDX_W-1:0]    res_idx
);

    logic                in_frame_q;
    logic [ROW_W-1:0]    row_q;
    logic [COL_W-1:0]    col_q;
    logic [SAMPLE_W-1:0] run_max_q;
    logic [IDX_W-1:0]    run_idx_q;

    logic                active;
    logic                take;
    logic                last;
    logic [ROW_W-1:0]    pos_row;
    logic [COL_W-1:0]    pos_col;
    logic [SAMPLE_W:0]   diff;
    logic [SAMPLE_W-1:0] nxt_max;
    logic [IDX_W-1:0]    nxt_idx;

    always_comb begin
        pos_row = in_s.first ? '0 : row_q;
        pos_col = in_s.first ? '0 : col_q;
        active  = in_s.valid && (in_s.first || in_frame_q);
        // Sign of the difference picks the survivor; zero keeps the older one.
        diff    = {1'b0, in_s.data} - {1'b0, run_max_q};
        take    = in_s.first || (!diff[SAMPLE_W] && (diff[SAMPLE_W-1:0] != '0));
        last    = (pos_row == ROW_W'(ROWS - 1)) && (pos_col == COL_W'(COLS - 1));
        nxt_max = take ? in_s.data : run_max_q;
        nxt_idx = take ? {pos_row, pos_col} : run_idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            row_q      <= '0;
            col_q      <= '0;
            run_max_q  <= '0;
            run_idx_q  <= '0;
            res_valid  <= 1'b0;
            res_max    <= '0;
            res_idx    <= '0;
        end else begin
            res_valid <= 1'b0;
            if (active) begin
                run_max_q <= nxt_max;
                run_idx_q <= nxt_idx;
                if (last) begin
                    res_valid  <= 1'b1;
                    res_max    <= nxt_max;
                    res_idx    <= nxt_idx;
                    in_frame_q <= 1'b0;
                    row_q      <= '0;
                    col_q      <= '0;
                end else begin
                    in_frame_q <= 1'b1;
                    if (pos_col == COL_W'(COLS - 1)) begin
                        col_q <= '0;
                        row_q <= pos_row + 1'b1;
                    end else begin
                        col_q <= pos_col + 1'b1;
                        row_q <= pos_row;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/energy_front_end.sv
module energy_front_end
    import efe_pkg::*;
#(
    parameter int unsigned ROWS = 20,
    parameter int unsigned COLS = 20,
    localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned COL_W = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int unsigned IDX_W = ROW_W + COL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                word_strobe,
    input  logic                frame_start,
    input  logic [WORD_W-1:0]   chan_a_word,
    input  logic [WORD_W-1:0]   chan_b_word,
    output logic                sum_valid,
    output logic [SAMPLE_W-1:0] sum_data,
    output logic                max_valid,
    output logic [SAMPLE_W-1:0] max_value,
    output logic [IDX_W-1:0]    max_index
);

    localparam int unsigned NCH = 2;

    logic [WORD_W-1:0] chan_words [NCH];
    sample_t           ser_s      [NCH];
    sample_t           ser_a;
    sample_t           ser_b;
    sample_t           sum_s;

    assign chan_words[0] = chan_a_word;
    assign chan_words[1] = chan_b_word;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        chan_serializer u_ser (
            .clk      (clk),
            .rst      (rst),
            .strobe   (word_strobe),
            .first_in (frame_start),
            .word     (chan_words[c]),
            .out_s    (ser_s[c])
        );
    end

    assign ser_a = ser_s[0];
    assign ser_b = ser_s[1];

    sat_sum_stage u_sum (
        .clk   (clk),
        .rst   (rst),
        .a_s   (ser_a),
        .b_s   (ser_b),
        .sum_s (sum_s)
    );

    map_max_tracker #(
        .ROWS (ROWS),
        .COLS (COLS)
    ) u_max (
        .clk       (clk),
        .rst       (rst),
        .in_s      (sum_s),
        .res_valid (max_valid),
        .res_max   (max_value),
        .res_idx   (max_index)
    );

    assign sum_valid = sum_s.valid;
    assign sum_data  = sum_s.data;

endmodule

// File: rtl/efe_checker.sv
module efe_checker
    import efe_pkg::*;
#(
    parameter int unsigned ROWS = 20,
    parameter int unsigned COLS = 20,
    localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned COL_W = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int unsigned IDX_W = ROW_W + COL_W
) (
    input logic                clk,
    input logic                rst,
    input logic                word_strobe,
    input logic                ser_valid,
    input logic [SAMPLE_W-1:0] a_data,
    input logic [SAMPLE_W-1:0] b_data,
    input logic                sum_valid,
    input logic [SAMPLE_W-1:0] sum_data,
    input logic                max_valid,
    input logic [SAMPLE_W-1:0] max_value,
    input logic [IDX_W-1:0]    max_index
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2: a strobe yields a summed sample two edges later
    a_r2_strobe_to_sum: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(word_strobe, 2)) |-> sum_valid);

    // R3: the sum never falls below either addend (no wrap)
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && ser_valid) |=>
            (sum_valid && sum_data >= $past(a_data) && sum_data >= $past(b_data)));

    // R7: reported index fields stay inside the map
    a_r7_index_in_map: assert property (@(posedge clk) disable iff (rst)
        max_valid |-> (max_index[COL_W-1:0] < COL_W'(COLS) &&
                       max_index[IDX_W-1:COL_W] < ROW_W'(ROWS)));

    // R8: result pulse lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        max_valid |=> !max_valid);

    // R8: a result follows a valid summed sample
    a_r8_after_sample: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && max_valid) |-> $past(sum_valid));

    // R8: result holds between pulses
    a_r8_result_holds: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && !max_valid) |-> ($stable(max_value) && $stable(max_index)));

endmodule

bind energy_front_end efe_checker #(
    .ROWS (ROWS),
    .COLS (COLS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .word_strobe (word_strobe),
    .ser_valid   (ser_a.valid),
    .a_data      (ser_a.data),
    .b_data      (ser_b.data),
    .sum_valid   (sum_valid),
    .sum_data    (sum_data),
    .max_valid   (max_valid),
    .max_value   (max_value),
    .max_index   (max_index)
);

// File: tb/energy_front_end_tb.sv
module energy_front_end_tb;

    localparam int NW = 200;
    localparam int NS = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_strobe = 1'b0;
    logic        frame_start = 1'b0;
    logic [31:0] chan_a_word = '0;
    logic [31:0] chan_b_word = '0;
    logic        sum_valid;
    logic [15:0] sum_data;
    logic        max_valid;
    logic [15:0] max_value;
    logic [9:0]  max_index;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [15:0] exp_sum [$];
    logic [25:0] exp_res [$];
    logic [15:0] last_max = '0;
    logic [9:0]  last_idx = '0;
    logic [31:0] wa [NW];
    logic [31:0] wb [NW];

    energy_front_end u_dut (
        .clk         (clk),
        .rst         (rst),
        .word_strobe (word_strobe),
        .frame_start (frame_start),
        .chan_a_word (chan_a_word),
        .chan_b_word (chan_b_word),
        .sum_valid   (sum_valid),
        .sum_data    (sum_data),
        .max_valid   (max_valid),
        .max_value   (max_value),
        .max_index   (max_index)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] sat16(input logic [15:0] x, input logic [15:0] y);
        logic [16:0] w;
        w = {1'b0, x} + {1'b0, y};
        return w[16] ? 16'hFFFF : w[15:0];
    endfunction

    function automatic logic [15:0] samp(input int p);
        logic [31:0] a;
        logic [31:0] b;
        a = wa[p / 2];
        b = wb[p / 2];
        return (p % 2 == 0) ? sat16(a[15:0], b[15:0]) : sat16(a[31:16], b[31:16]);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL R5 watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Monitor: R3 R4 sum stream order and value, R6 R7 R9 map results
    always @(negedge clk) begin
        if (!rst) begin
            if (sum_valid) begin
                if (exp_sum.size() == 0) chk(1'b0, "R4", "unexpected sample", sum_data, 0);
                else begin
                    logic [15:0] e;
                    e = exp_sum.pop_front();
                    chk(sum_data == e, "R3", "summed sample", sum_data, e);
                end
            end
            if (max_valid) begin
                if (exp_res.size() == 0) chk(1'b0, "R9", "unexpected result", max_value, 0);
                else begin
                    logic [25:0] r;
                    r = exp_res.pop_front();
                    chk(max_value == r[25:10], "R6", "map maximum", max_value, r[25:10]);
                    chk(max_index == r[9:0], "R7", "map index", max_index, r[9:0]);
                end
            end
        end
    end

    // Called at a negedge; returns at the negedge where the next strobe may go.
    task automatic send_word(input logic [31:0] a, input logic [31:0] b,
                             input bit fs, input int gap);
        word_strobe = 1'b1;
        frame_start = fs;
        chan_a_word = a;
        chan_b_word = b;
        exp_sum.push_back(sat16(a[15:0], b[15:0]));
        exp_sum.push_back(sat16(a[31:16], b[31:16]));
        @(negedge clk);
        word_strobe = 1'b0;
        frame_start = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic fill(input int mode);
        for (int t = 0; t < NW; t++) begin
            case (mode)
                0: begin wa[t] = $urandom; wb[t] = $urandom; end
                1: begin wa[t] = $urandom & 32'h3FFF_3FFF; wb[t] = $urandom & 32'h3FFF_3FFF; end
                2: begin wa[t] = '0; wb[t] = '0; end
                3: begin wa[t] = 32'h1234_1234; wb[t] = 32'h1234_1234; end
                4: begin wa[t] = $urandom & 32'h3FFF_3FFF; wb[t] = $urandom & 32'h3FFF_3FFF; end
                5: begin wa[t] = 32'hFFFF_FFFF; wb[t] = $urandom | 32'h0001_0001; end
                default: begin wa[t] = $urandom & 32'h0FFF_0FFF; wb[t] = $urandom & 32'h0FFF_0FFF; end
            endcase
        end
        if (mode == 4) begin
            wa[NW-1][31:16] = 16'h8000;
            wb[NW-1][31:16] = 16'h7FFF;
        end
        if (mode == 6) begin
            // samples 57 (odd, high half of word 28) and 300 (even, word 150)
            wa[28][31:16] = 16'h7000; wb[28][31:16] = 16'h0000;
            wa[150][15:0] = 16'h3000; wb[150][15:0] = 16'h4000;
        end
    endtask

    task automatic run_frame(input int mode, input int gap, input bit with_start);
        logic [15:0] mx;
        int          mp;
        fill(mode);
        mx = samp(0);
        mp = 0;
        for (int p = 1; p < NS; p++) begin
            if (samp(p) > mx) begin mx = samp(p); mp = p; end
        end
        if (with_start) exp_res.push_back({mx, 5'(mp / 20), 5'(mp % 20)});
        for (int t = 0; t < NW - 1; t++) send_word(wa[t], wb[t], with_start && t == 0, gap);
        // Last word with explicit R8 timing checks.
        word_strobe = 1'b1;
        frame_start = 1'b0;
        chan_a_word = wa[NW-1];
        chan_b_word = wb[NW-1];
        exp_sum.push_back(sat16(wa[NW-1][15:0], wb[NW-1][15:0]));
        exp_sum.push_back(sat16(wa[NW-1][31:16], wb[NW-1][31:16]));
        @(negedge clk);
        word_strobe = 1'b0;
        @(negedge clk);
        chk(max_valid == 1'b0, "R8", "no pulse before last sample", max_valid, 0);
        @(negedge clk);
        chk(max_valid == 1'b0, "R8", "no pulse with last sample", max_valid, 0);
        @(negedge clk);
        chk(max_valid == with_start, "R8", "pulse cycle", max_valid, with_start);
        @(negedge clk);
        chk(max_valid == 1'b0, "R8", "pulse width", max_valid, 0);
        if (with_start) begin
            last_max = mx;
            last_idx = {5'(mp / 20), 5'(mp % 20)};
        end
        repeat (3) @(negedge clk);
        chk(max_value == last_max, "R8", "value held", max_value, last_max);
        chk(max_index == last_idx, "R8", "index held", max_index, last_idx);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(sum_valid == 1'b0 && max_valid == 1'b0, "R1", "valids in reset",
            {sum_valid, max_valid}, 0);
        chk(sum_data == '0 && max_value == '0 && max_index == '0, "R1", "data in reset",
            {sum_data, max_value, max_index}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sum_valid == 1'b0 && max_valid == 1'b0 && max_value == '0, "R1",
            "after release", {sum_valid, max_valid, max_value}, 0);

        // R2: half order and latency, outside any map
        word_strobe = 1'b1;
        chan_a_word = 32'h0002_0001;
        chan_b_word = 32'h0020_0010;
        exp_sum.push_back(16'h0011);
        exp_sum.push_back(16'h0022);
        @(negedge clk);
        word_strobe = 1'b0;
        chk(sum_valid == 1'b0, "R2", "no sample after one edge", sum_valid, 0);
        @(negedge clk);
        chk(sum_valid && sum_data == 16'h0011, "R2", "low half first", sum_data, 16'h0011);
        @(negedge clk);
        chk(sum_valid && sum_data == 16'h0022, "R2", "high half second", sum_data, 16'h0022);
        @(negedge clk);
        chk(sum_valid == 1'b0, "R2", "stream idle", sum_valid, 0);
        chk(max_valid == 1'b0, "R9", "no result outside map", max_valid, 0);
        repeat (2) @(negedge clk);

        run_frame(0, 2, 1'b1);   // R3 R5 R6 random, many clamps
        run_frame(1, 3, 1'b1);   // R4 gapped strobes
        run_frame(2, 2, 1'b1);   // R7 all zero: tie at origin
        run_frame(3, 2, 1'b1);   // R7 all equal
        run_frame(4, 2, 1'b1);   // R7 peak at row 19 col 19
        run_frame(5, 3, 1'b1);   // R3 every sum clamps
        run_frame(6, 2, 1'b1);   // R7 duplicate peak: earlier wins
        run_frame(0, 2, 1'b0);   // R9 no frame start: ignored
        run_frame(1, 2, 1'b1);   // R9 next map unaffected
        for (int k = 0; k < 4; k++) run_frame(k % 2, 2 + (k % 2), 1'b1);

        repeat (5) @(negedge clk);
        chk(exp_sum.size() == 0, "R4", "all samples delivered", exp_sum.size(), 0);
        chk(exp_res.size() == 0, "R5", "all maps reported", exp_res.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule